// File: doc/BRIEF.md
# Pipeline Serialization and Fence Controller

This controller sits between decode and issue in an in-order-issue core whose instructions may complete out of order. Each decoded instruction arrives with a class code and its operand details: a control-register number and a model-specific-register index. The controller resolves them into one of five ordering kinds: ordinary, fully serializing, load fence, store fence or full memory fence. Any kind other than ordinary is captured, and the controller then stalls younger work, waits until the pipeline state that kind depends on has drained, and releases the held instruction with a single-cycle execute grant. It then waits for a completion pulse before it lets issue resume.

Only fully serializing instructions stop instruction fetch and discard younger speculatively fetched work. Memory fences keep the front end running and only hold back issue. The explicit write-back-and-invalidate class is the only class that raises a cache flush request. Its completion is the external cache-done pulse, which may arrive after any number of cycles. Writes to control register 8 and model-specific-register writes to a few timer and interrupt-controller indices are exempt from serialization and behave as ordinary instructions.

Top module: `ser_fence_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every output is low in the following cycle and the controller is idle.
- R2: Class codes are: 0 plain, 1 always-serializing, 2 control-register write, 3 debug-register write, 4 model-specific-register write, 5 load fence, 6 store fence, 7 full memory fence, 8 write-back-and-invalidate. Class 0 with `dec_valid` leaves all outputs low.
- R3: A serializing instruction accepted while idle raises `issue_stall` and `fetch_stall` in the next cycle, and `flush_young` is high for exactly that one cycle.
- R4: A serializing instruction gets `exec_go` only after a cycle in which `inflight_cnt` is 0 and `sb_empty` is 1 has been sampled during the drain. `exec_go` is high for exactly one cycle, the one after that sample.
- R5: A model-specific-register write serializes, except for index 0x6E0 and indices 0x802 to 0x83F inclusive, which are ordinary. Indices 0x801 and 0x840 serialize.
- R6: A control-register write to register 8 is ordinary. Writes to any other control register, and all debug-register writes, serialize.
- R7: A load fence waits only for `inflight_cnt` to be 0 and ignores `sb_empty`. It raises `issue_stall` but never `fetch_stall` or `flush_young`.
- R8: A store fence waits only for `sb_empty`. It raises `issue_stall` but never `fetch_stall` or `flush_young`.
- R9: A full memory fence waits for `sb_empty` high and `ld_outst` zero at the same time. It never raises `fetch_stall` or `flush_young`.
- R10: An `op_done` pulse while the controller waits for completion releases `fetch_stall` in the next cycle, keeps `issue_stall` high for that one cycle, and clears all stalls in the cycle after. An `op_done` pulse at any other time has no effect.
- R11: The write-back-and-invalidate class serializes and raises `cache_flush_req` together with `exec_go`. The request stays high until a `cache_done` pulse, which completes the instruction. `op_done` is ignored for this class, and no other class ever raises `cache_flush_req`.
- R12: `dec_valid` is ignored while the controller is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_class | input | 4 | Instruction class code |
| dec_creg | input | CR_W | Control-register number for class 2 |
| dec_msr | input | MSR_W | Model-specific-register index for class 4 |
| inflight_cnt | input | CNT_W | Older instructions not yet completed |
| sb_empty | input | 1 | Store buffer holds no writes |
| ld_outst | input | LDC_W | Outstanding loads |
| op_done | input | 1 | Completion pulse of the held instruction |
| cache_done | input | 1 | Cache write-back-and-invalidate finished |
| fetch_stall | output | 1 | Hold instruction fetch |
| issue_stall | output | 1 | Hold issue of younger instructions |
| flush_young | output | 1 | Discard younger speculative work |
| exec_go | output | 1 | Held instruction may execute |
| cache_flush_req | output | 1 | Request cache write-back-and-invalidate |

## Verification
The bench targets the exemption boundaries. Indices 0x6E0, 0x802 and 0x83F must stay ordinary, while 0x801, 0x840 and control registers 3 and 8 must land on the correct side. An off-by-one range compare would let a neighbouring index slip through, or would stall on an exempt one. Each fence kind is held with exactly one of its drain conditions unmet: a load fence is held with the store buffer full, and a full fence is held with loads outstanding. A design that mixed up the drain conditions would grant `exec_go` too early or hang. Completion pulses are sent outside the wait state, and `op_done` is sent to the cache-flush class. A controller that honoured either pulse would release the stalls before the instruction had finished.

// File: rtl/ser_fence_pkg.sv
package ser_fence_pkg;

    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        CL_PLAIN     = 4'd0,
        CL_SERIAL    = 4'd1,
        CL_CR_WR     = 4'd2,
        CL_DR_WR     = 4'd3,
        CL_MSR_WR    = 4'd4,
        CL_LD_FENCE  = 4'd5,
        CL_ST_FENCE  = 4'd6,
        CL_MEM_FENCE = 4'd7,
        CL_WB_INV    = 4'd8
    } instr_class_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SER   = 3'd1,
        K_LOAD  = 3'd2,
        K_STORE = 3'd3,
        K_FULL  = 3'd4
    } order_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_EXEC   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_RESUME = 3'd4
    } ctl_state_e;

    typedef struct packed {
        order_kind_e kind;
        logic        wb;
    } order_req_t;

    function automatic logic stops_front_end(order_kind_e k);
        return k == K_SER;
    endfunction

endpackage

// File: rtl/ser_classify.sv
module ser_classify
    import ser_fence_pkg::*;
#(
    parameter int CR_W      = 4,
    parameter int MSR_W     = 12,
    parameter int CR_EXEMPT = 8,
    parameter int MSR_SOLO  = 'h6E0,
    parameter int MSR_LO    = 'h802,
    parameter int MSR_HI    = 'h83F
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [CR_W-1:0]    creg,
    input  logic [MSR_W-1:0]   msr,
    output order_req_t         req
);
    localparam logic [CR_W-1:0]  CR_X  = CR_W'(CR_EXEMPT);
    localparam logic [MSR_W-1:0] M_ONE = MSR_W'(MSR_SOLO);
    localparam logic [MSR_W-1:0] M_LO  = MSR_W'(MSR_LO);
    localparam logic [MSR_W-1:0] M_HI  = MSR_W'(MSR_HI);

    logic msr_exempt;
    assign msr_exempt = (msr == M_ONE) || ((msr >= M_LO) && (msr <= M_HI));

    always_comb begin
        req = '{kind: K_NONE, wb: 1'b0};
        case (instr_class_e'(cls))
            CL_SERIAL, CL_DR_WR: req.kind = K_SER;
            CL_CR_WR:            req.kind = (creg == CR_X) ? K_NONE : K_SER;
            CL_MSR_WR:           req.kind = msr_exempt ? K_NONE : K_SER;
            CL_LD_FENCE:         req.kind = K_LOAD;
            CL_ST_FENCE:         req.kind = K_STORE;
            CL_MEM_FENCE:        req.kind = K_FULL;
            CL_WB_INV:           req = '{kind: K_SER, wb: 1'b1};
            default:             req = '{kind: K_NONE, wb: 1'b0};
        endcase
    end
endmodule

// File: rtl/ser_drain_check.sv
module ser_drain_check
    import ser_fence_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int LDC_W = 5
) (
    input  order_kind_e        kind,
    input  logic [CNT_W-1:0]   inflight_cnt,
    input  logic               sb_empty,
    input  logic [LDC_W-1:0]   ld_outst,
    output logic               ready
);
    logic older_done, loads_done;
    assign older_done = (inflight_cnt == '0);
    assign loads_done = (ld_outst == '0);

    always_comb begin
        case (kind)
            K_SER:   ready = older_done && sb_empty;
            K_LOAD:  ready = older_done;
            K_STORE: ready = sb_empty;
            K_FULL:  ready = sb_empty && loads_done;
            default: ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/ser_fence_ctrl.sv
module ser_fence_ctrl
    import ser_fence_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int LDC_W     = 5,
    parameter int CR_W      = 4,
    parameter int MSR_W     = 12,
    parameter int CR_EXEMPT = 8,
    parameter int MSR_SOLO  = 'h6E0,
    parameter int MSR_LO    = 'h802,
    parameter int MSR_HI    = 'h83F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dec_valid,
    input  logic [3:0]         dec_class,
    input  logic [CR_W-1:0]    dec_creg,
    input  logic [MSR_W-1:0]   dec_msr,
    input  logic [CNT_W-1:0]   inflight_cnt,
    input  logic               sb_empty,
    input  logic [LDC_W-1:0]   ld_outst,
    input  logic               op_done,
    input  logic               cache_done,
    output logic               fetch_stall,
    output logic               issue_stall,
    output logic               flush_young,
    output logic               exec_go,
    output logic               cache_flush_req
);
    order_req_t dec_req, held_q, held_d;
    ctl_state_e state_q, state_d;
    logic       drain_ok, done_evt, capture, busy_d;

    ser_classify #(
        .CR_W(CR_W), .MSR_W(MSR_W), .CR_EXEMPT(CR_EXEMPT),
        .MSR_SOLO(MSR_SOLO), .MSR_LO(MSR_LO), .MSR_HI(MSR_HI)
    ) u_cls (
        .cls(dec_class), .creg(dec_creg), .msr(dec_msr), .req(dec_req)
    );

    ser_drain_check #(.CNT_W(CNT_W), .LDC_W(LDC_W)) u_drn (
        .kind(held_q.kind), .inflight_cnt(inflight_cnt),
        .sb_empty(sb_empty), .ld_outst(ld_outst), .ready(drain_ok)
    );

    assign capture  = (state_q == ST_IDLE) && dec_valid && (dec_req.kind != K_NONE);
    assign done_evt = held_q.wb ? cache_done : op_done;

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        case (state_q)
            ST_IDLE:   if (capture) begin
                           state_d = ST_DRAIN;
                           held_d  = dec_req;
                       end
            ST_DRAIN:  if (drain_ok) state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_WAIT;
            ST_WAIT:   if (done_evt) state_d = ST_RESUME;
            ST_RESUME: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign busy_d = (state_d == ST_DRAIN) || (state_d == ST_EXEC) || (state_d == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= ST_IDLE;
            held_q          <= '{kind: K_NONE, wb: 1'b0};
            fetch_stall     <= 1'b0;
            issue_stall     <= 1'b0;
            flush_young     <= 1'b0;
            exec_go         <= 1'b0;
            cache_flush_req <= 1'b0;
        end else begin
            state_q         <= state_d;
            held_q          <= held_d;
            fetch_stall     <= busy_d && stops_front_end(held_d.kind);
            issue_stall     <= (state_d != ST_IDLE);
            flush_young     <= capture && stops_front_end(dec_req.kind);
            exec_go         <= (state_d == ST_EXEC);
            cache_flush_req <= held_d.wb && ((state_d == ST_EXEC) || (state_d == ST_WAIT));
        end
    end
endmodule

// File: rtl/ser_fence_chk.sv
module ser_fence_chk
    import ser_fence_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input ctl_state_e       state,
    input order_req_t       held,
    input logic [CNT_W-1:0] inflight_cnt,
    input logic             sb_empty,
    input logic             op_done,
    input logic             cache_done,
    input logic             fetch_stall,
    input logic             issue_stall,
    input logic             flush_young,
    input logic             exec_go,
    input logic             cache_flush_req
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!fetch_stall && !issue_stall && !flush_young && !exec_go && !cache_flush_req));

    a_r3_flush_single: assert property (@(posedge clk) disable iff (rst)
        flush_young |=> !flush_young);

    a_r3_flush_with_stalls: assert property (@(posedge clk) disable iff (rst)
        flush_young |-> (fetch_stall && issue_stall));

    a_r4_exec_after_drain: assert property (@(posedge clk) disable iff (rst)
        (exec_go && held.kind == K_SER) |-> $past(inflight_cnt == '0 && sb_empty));

    a_r4_exec_single: assert property (@(posedge clk) disable iff (rst)
        exec_go |=> !exec_go);

    a_r7_load_front_free: assert property (@(posedge clk) disable iff (rst)
        (held.kind == K_LOAD && state != ST_IDLE) |-> (!fetch_stall && !flush_young));

    a_r8_mem_front_free: assert property (@(posedge clk) disable iff (rst)
        ((held.kind == K_STORE || held.kind == K_FULL) && state != ST_IDLE) |-> !fetch_stall);

    a_r10_resume: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !held.wb && op_done) |=> (!fetch_stall && issue_stall));

    a_r11_flush_only_wb: assert property (@(posedge clk) disable iff (rst)
        cache_flush_req |-> held.wb);

    a_r11_flush_held: assert property (@(posedge clk) disable iff (rst)
        (cache_flush_req && !cache_done) |=> cache_flush_req);
endmodule

bind ser_fence_ctrl ser_fence_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .state(state_q), .held(held_q),
    .inflight_cnt(inflight_cnt), .sb_empty(sb_empty),
    .op_done(op_done), .cache_done(cache_done),
    .fetch_stall(fetch_stall), .issue_stall(issue_stall),
    .flush_young(flush_young), .exec_go(exec_go),
    .cache_flush_req(cache_flush_req)
);

// File: tb/ser_fence_ctrl_tb.sv
module ser_fence_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [3:0]  dec_class = '0;
    logic [3:0]  dec_creg = '0;
    logic [11:0] dec_msr = '0;
    logic [5:0]  inflight_cnt = '0;
    logic        sb_empty = 1'b1;
    logic [4:0]  ld_outst = '0;
    logic        op_done = 1'b0;
    logic        cache_done = 1'b0;
    logic fetch_stall, issue_stall, flush_young, exec_go, cache_flush_req;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    ser_fence_ctrl u_dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_creg(dec_creg), .dec_msr(dec_msr), .inflight_cnt(inflight_cnt),
        .sb_empty(sb_empty), .ld_outst(ld_outst), .op_done(op_done),
        .cache_done(cache_done), .fetch_stall(fetch_stall),
        .issue_stall(issue_stall), .flush_young(flush_young),
        .exec_go(exec_go), .cache_flush_req(cache_flush_req)
    );

    always #10 clk = ~clk;

    // Reference model: phase 0 idle, 1 drain, 2 execute, 3 wait, 4 resume
    // kind 0 none, 1 serialize, 2 load, 3 store, 4 full
    int m_phase = 0, m_kind = 0;
    bit m_wb = 0, m_live = 0;
    bit e_fetch = 0, e_issue = 0, e_flush = 0, e_exec = 0, e_cflush = 0;

    function automatic void classify(input int cls, input int cr, input int msr,
                                     output int kind, output bit wb);
        wb = 0; kind = 0;
        if (cls == 1 || cls == 3) kind = 1;
        else if (cls == 2) kind = (cr == 8) ? 0 : 1;
        else if (cls == 4) kind = (msr == 'h6E0 || (msr >= 'h802 && msr <= 'h83F)) ? 0 : 1;
        else if (cls == 5) kind = 2;
        else if (cls == 6) kind = 3;
        else if (cls == 7) kind = 4;
        else if (cls == 8) begin kind = 1; wb = 1; end
    endfunction

    always @(posedge clk) begin
        int nk; bit nw; bit ready; bit flush_now;
        m_live = 1;
        flush_now = 0;
        if (rst) begin
            m_phase = 0; m_kind = 0; m_wb = 0;
        end else begin
            case (m_phase)
                0: if (dec_valid) begin
                       classify(dec_class, dec_creg, dec_msr, nk, nw);
                       if (nk != 0) begin
                           m_phase = 1; m_kind = nk; m_wb = nw;
                           flush_now = (nk == 1);
                       end
                   end
                1: begin
                       if (m_kind == 1) ready = (inflight_cnt == 0) && sb_empty;
                       else if (m_kind == 2) ready = (inflight_cnt == 0);
                       else if (m_kind == 3) ready = sb_empty;
                       else ready = sb_empty && (ld_outst == 0);
                       if (ready) m_phase = 2;
                   end
                2: m_phase = 3;
                3: if (m_wb ? cache_done : op_done) m_phase = 4;
                default: m_phase = 0;
            endcase
        end
        e_issue  = (m_phase != 0);
        e_fetch  = (m_kind == 1) && (m_phase >= 1) && (m_phase <= 3);
        e_flush  = flush_now;
        e_exec   = (m_phase == 2);
        e_cflush = m_wb && (m_phase == 2 || m_phase == 3);
    end

    task automatic cmp(string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live) begin
            cmp("fetch_stall", fetch_stall, e_fetch);
            cmp("issue_stall", issue_stall, e_issue);
            cmp("flush_young", flush_young, e_flush);
            cmp("exec_go", exec_go, e_exec);
            cmp("cache_flush_req", cache_flush_req, e_cflush);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic present(int cls, int cr, int msr);
        dec_valid = 1; dec_class = 4'(cls); dec_creg = 4'(cr); dec_msr = 12'(msr);
        tick(1);
        dec_valid = 0;
    endtask

    task automatic service(bit wb);
        for (int i = 0; i < 100 && !exec_go; i++) tick(1);
        tick(2);
        op_done = 1; tick(1); op_done = 0;
        if (wb) begin
            tick(3);
            cache_done = 1; tick(1); cache_done = 0;
        end
        tick(4);
    endtask

    task automatic ordinary_case(string tag, int cls, int cr, int msr);
        cur_req = tag;
        present(cls, cr, msr);
        tick(2);
        cmp({tag, " no stall"}, issue_stall | fetch_stall, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        cur_req = "R1";
        cmp("R1 reset issue_stall", issue_stall, 1'b0);
        cmp("R1 reset exec_go", exec_go, 1'b0);
        rst = 0;
        tick(2);

        ordinary_case("R2", 0, 0, 0);
        op_done = 1; tick(1); op_done = 0; tick(2);   // R10 stray completion while idle
        ordinary_case("R6", 2, 8, 0);
        ordinary_case("R5", 4, 0, 'h6E0);
        ordinary_case("R5", 4, 0, 'h802);
        ordinary_case("R5", 4, 0, 'h83F);

        // R3 / R4: serialize held by busy pipeline and full store buffer
        cur_req = "R4";
        inflight_cnt = 3; sb_empty = 0;
        present(1, 0, 0);
        cmp("R3 flush pulse", flush_young, 1'b1);
        cmp("R3 fetch stall", fetch_stall, 1'b1);
        cur_req = "R12";
        dec_valid = 1; dec_class = 4'd5; tick(2); dec_valid = 0;
        cur_req = "R4";
        tick(2);
        inflight_cnt = 0; tick(3);
        cmp("R4 no early exec", exec_go, 1'b0);
        sb_empty = 1;
        cur_req = "R10";
        service(0);

        cur_req = "R6"; present(2, 3, 0); service(0);
        cur_req = "R6"; present(3, 0, 0); service(0);
        cur_req = "R5"; present(4, 0, 'h801); service(0);
        cur_req = "R5"; present(4, 0, 'h840); service(0);

        // R7: load fence ignores store buffer
        cur_req = "R7";
        inflight_cnt = 2; sb_empty = 0;
        present(5, 0, 0);
        tick(3);
        inflight_cnt = 0;
        service(0);
        sb_empty = 1;

        // R8: store fence waits on store buffer only
        cur_req = "R8";
        inflight_cnt = 5; sb_empty = 0;
        present(6, 0, 0);
        tick(3);
        sb_empty = 1;
        service(0);
        inflight_cnt = 0;

        // R9: full fence waits on loads as well
        cur_req = "R9";
        ld_outst = 2;
        present(7, 0, 0);
        tick(4);
        cmp("R9 held by loads", exec_go, 1'b0);
        ld_outst = 0;
        service(0);

        // R11: write-back-and-invalidate ends only on cache_done
        cur_req = "R11";
        present(8, 0, 0);
        service(1);
        cmp("R11 idle after", issue_stall, 1'b0);

        tick(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule